// File: doc/BRIEF.md
# Dual-Target Interrupt Pending Controller

This block gathers eleven interrupt sources and reports them to two processors: a main CPU and a sound CPU. Each processor, called a target here, has its own pending, enable and clear registers. A source event marks the pending flag of that source in both targets. Each target then decides on its own, through its enable register, whether the flag drives its interrupt line. Software clears a flag by writing a one to the matching bit of the target's clear register. Software can also raise a software interrupt on one target by writing a one to bit 5 of that target's pending register.

The sources are as follows. Three active-low external lines are synchronized and act on their falling edge. A DMA-done pulse and three timer overflow pulses also set flags. An internal per-sample tick fires once every `SAMPLE_DIV` clocks, which is one 44.1 kHz sample period at the default clock. Two FIFO status levels are also sources: MIDI input data available and MIDI output FIFO empty. Their flags track the live level, so they drop by themselves when the condition ends.

Software reaches the registers through a 16-bit port. A write takes effect on the clock edge where `reg_wr` is high. A read is a small stream. Raising `reg_rd` for one cycle makes the block return `rd_valid` with `rd_data` on the next cycle. The read path has no ready signal because the consumer must always accept, so there is no back-pressure. A read issued every cycle returns one result every cycle.

Top module: `irq_dual_ctrl`

## Requirements
- R1: A source event sets its pending flag in both targets whatever the enable bits hold, and the flag stays set until it is cleared.
- R2: Writing 1 to a bit of a target's clear register (main at offset 2, sound at offset 6) clears that target's pending flag for that bit. Zero bits in the write change nothing, and the other target is not affected.
- R3: A write to a target's pending register (main at offset 0, sound at offset 4) sets bit 5 of that target when data bit 5 is 1. Every other data bit, and a 0 in bit 5, has no effect.
- R4: External inputs `ext_irq_n[2:0]` map to pending bits 0 to 2. A flag is set once per high-to-low transition, after synchronization. A line held low does not set the flag again once software has cleared it.
- R5: `dma_done` sets pending bit 4, and `tmr_ovf[2:0]` set pending bits 6, 7 and 8.
- R6: Pending bit 3 equals `midi_in_avail` and pending bit 9 equals `midi_out_empty`, as live levels. A clear write does not remove either bit while its level is high.
- R7: When a source event and a clear write for the same bit fall in the same cycle, the flag ends up set.
- R8: `irq_main` and `irq_sound` equal the OR over bits 0 to 10 of (pending AND enable) of their target, delayed by one register. Enable registers are at offset 1 (main) and offset 5 (sound).
- R9: Register bits 15 to 11 read as 0 and ignore writes. Clear registers and unused offsets read as 0.
- R10: The internal sample tick sets pending bit 10 exactly once every `SAMPLE_DIV` clocks.
- R11: Both targets take events from the same sources, but their pending, enable and clear state is independent.
- R12: Each `reg_rd` cycle produces exactly one `rd_valid` cycle, one clock later, carrying the register value as it stood at the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_irq_n | input | 3 | Active-low external interrupt lines, asynchronous |
| midi_in_avail | input | 1 | MIDI input FIFO holds data (level) |
| midi_out_empty | input | 1 | MIDI output FIFO is empty (level) |
| dma_done | input | 1 | DMA transfer complete pulse |
| tmr_ovf | input | 3 | Timer A/B/C overflow pulses |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read request |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 16 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after reg_rd |
| rd_data | output | 16 | Read data |
| irq_main | output | 1 | Main CPU interrupt request |
| irq_sound | output | 1 | Sound CPU interrupt request |

## Verification
The bench drives a clear write and a DMA pulse into the same edge. A design where the clear wins would lose that event. It holds an external line low after clearing its flag, which catches a level-triggered design that fires again. It writes 1 to every pending bit except bit 5, and a design that lets software forge hardware flags fails there. It also clears a FIFO-status bit while the level stays high and checks that the bit remains, and it measures the interval between sample ticks to catch an off-by-one divider.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NSRC   = 11;
  localparam int NEXT   = 3;
  localparam int NTMR   = 3;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 3;

  localparam int B_EXT0     = 0;
  localparam int B_MIDI_IN  = 3;
  localparam int B_DMA      = 4;
  localparam int B_SOFT     = 5;
  localparam int B_TMR0     = 6;
  localparam int B_MIDI_OUT = 9;
  localparam int B_TICK     = 10;

  localparam logic [NSRC-1:0] LVL_MASK = NSRC'((1 << B_MIDI_IN) | (1 << B_MIDI_OUT));

  typedef enum logic [1:0] {
    RS_PEND = 2'd0,
    RS_EN   = 2'd1,
    RS_CLR  = 2'd2,
    RS_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irq_ext_sync.sv
module irq_ext_sync #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] ext_n,
  output logic [N-1:0] fall
);
  logic [N-1:0] meta_q, sync_q, prev_q;

  generate
    for (genvar i = 0; i < N; i++) begin : g_line
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          meta_q[i] <= 1'b1;
          sync_q[i] <= 1'b1;
          prev_q[i] <= 1'b1;
        end else begin
          meta_q[i] <= ext_n[i];
          sync_q[i] <= meta_q[i];
          prev_q[i] <= sync_q[i];
        end
      end
      assign fall[i] = prev_q[i] & ~sync_q[i];

      AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        fall[i] |=> !fall[i]); // R4
    end
  endgenerate
endmodule

// File: rtl/irq_tick_gen.sv
module irq_tick_gen #(
  parameter int DIV = 4535
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end

  assign tick = (cnt_q == LAST);

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R10
endmodule

// File: rtl/irq_target_bank.sv
module irq_target_bank #(
  parameter int              NSRC     = 11,
  parameter logic [NSRC-1:0] LVL_BITS = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] evt_set,
  input  logic [NSRC-1:0] lvl_val,
  input  logic            en_wr,
  input  logic [NSRC-1:0] en_wdata,
  input  logic            clr_wr,
  input  logic [NSRC-1:0] clr_wdata,
  output logic [NSRC-1:0] pend,
  output logic [NSRC-1:0] en,
  output logic            irq
);
  localparam logic [NSRC-1:0] EDGE_BITS = ~LVL_BITS;

  logic [NSRC-1:0] clr_vec;
  assign clr_vec = clr_wr ? clr_wdata : '0;

  generate
    for (genvar i = 0; i < NSRC; i++) begin : g_bit
      if (LVL_BITS[i]) begin : g_lvl
        assign pend[i] = lvl_val[i];
      end else begin : g_edge
        logic flag_q;
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) flag_q <= 1'b0;
          else        flag_q <= (flag_q & ~clr_vec[i]) | evt_set[i];
        end
        assign pend[i] = flag_q;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en <= '0;
    else if (en_wr) en <= en_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= |(pend & en);
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_set & EDGE_BITS) != '0) |=>
      ((pend & $past(evt_set & EDGE_BITS)) == $past(evt_set & EDGE_BITS))); // R7

  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && ((clr_wdata & EDGE_BITS & ~evt_set) != '0)) |=>
      ((pend & $past(clr_wdata & EDGE_BITS & ~evt_set)) == '0)); // R2

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_wr && evt_set == '0) |=> ((pend & EDGE_BITS) == ($past(pend) & EDGE_BITS))); // R1

  AST_IRQ_REG: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == $past(|(pend & en)))); // R8
endmodule

// File: rtl/irq_dual_ctrl.sv
module irq_dual_ctrl
  import irq_pkg::*;
#(
  parameter int SAMPLE_DIV = 4535
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NEXT-1:0]   ext_irq_n,
  input  logic              midi_in_avail,
  input  logic              midi_out_empty,
  input  logic              dma_done,
  input  logic [NTMR-1:0]   tmr_ovf,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq_main,
  output logic              irq_sound
);
  localparam int NTGT = 2;

  logic [NEXT-1:0] ext_fall;
  logic            tick;
  logic [NSRC-1:0] hw_evt;
  logic [NSRC-1:0] lvl_vec;
  logic [NTGT-1:0] tgt_irq;
  logic [NSRC-1:0] tgt_pend [NTGT];
  logic [NSRC-1:0] tgt_en   [NTGT];

  irq_ext_sync #(.N(NEXT)) u_sync (
    .clk(clk), .rst_n(rst_n), .ext_n(ext_irq_n), .fall(ext_fall)
  );

  irq_tick_gen #(.DIV(SAMPLE_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  always_comb begin
    hw_evt = '0;
    hw_evt[B_EXT0 +: NEXT] = ext_fall;
    hw_evt[B_DMA]          = dma_done;
    hw_evt[B_TMR0 +: NTMR] = tmr_ovf;
    hw_evt[B_TICK]         = tick;
    lvl_vec = '0;
    lvl_vec[B_MIDI_IN]     = midi_in_avail;
    lvl_vec[B_MIDI_OUT]    = midi_out_empty;
  end

  reg_sel_e wsel;
  assign wsel = reg_sel_e'(reg_addr[1:0]);

  generate
    for (genvar t = 0; t < NTGT; t++) begin : g_tgt
      logic            hit;
      logic [NSRC-1:0] evt;
      assign hit = (reg_addr[2] == 1'(t)) && reg_wr;

      always_comb begin
        evt = hw_evt;
        evt[B_SOFT] = hit && (wsel == RS_PEND) && reg_wdata[B_SOFT];
      end

      irq_target_bank #(.NSRC(NSRC), .LVL_BITS(LVL_MASK)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_set  (evt),
        .lvl_val  (lvl_vec),
        .en_wr    (hit && (wsel == RS_EN)),
        .en_wdata (reg_wdata[NSRC-1:0]),
        .clr_wr   (hit && (wsel == RS_CLR)),
        .clr_wdata(reg_wdata[NSRC-1:0]),
        .pend     (tgt_pend[t]),
        .en       (tgt_en[t]),
        .irq      (tgt_irq[t])
      );
    end
  endgenerate

  assign irq_main  = tgt_irq[0];
  assign irq_sound = tgt_irq[1];

  logic [NSRC-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    unique case (reg_sel_e'(reg_addr[1:0]))
      RS_PEND: rd_mux = tgt_pend[reg_addr[2]];
      RS_EN:   rd_mux = tgt_en[reg_addr[2]];
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= reg_rd;
      if (reg_rd) rd_data <= {{(DATA_W-NSRC){1'b0}}, rd_mux};
    end
  end

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (rd_data[DATA_W-1:NSRC] == '0)); // R9

  AST_RD_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (rd_valid == $past(reg_rd))); // R12
endmodule

// File: tb/tb_irq_dual_ctrl.sv
`timescale 1ns/1ps
module tb_irq_dual_ctrl;
  localparam int DIV = 2000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  ext_irq_n = 3'b111;
  logic        midi_in_avail = 1'b0;
  logic        midi_out_empty = 1'b0;
  logic        dma_done = 1'b0;
  logic [2:0]  tmr_ovf = 3'b000;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic        rd_valid;
  logic [15:0] rd_data;
  logic        irq_main, irq_sound;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  logic [15:0] q_exp[$];
  string       q_tag[$];
  logic [10:0] mp = '0, sp = '0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  irq_dual_ctrl #(.SAMPLE_DIV(DIV)) dut (
    .clk(clk), .rst_n(rst_n), .ext_irq_n(ext_irq_n),
    .midi_in_avail(midi_in_avail), .midi_out_empty(midi_out_empty),
    .dma_done(dma_done), .tmr_ovf(tmr_ovf), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .rd_valid(rd_valid),
    .rd_data(rd_data), .irq_main(irq_main), .irq_sound(irq_sound)
  );

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: pops expected read results as the design returns them.
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (q_exp.size() == 0) check("R12 unexpected rd_valid", 16'h1, 16'h0);
      else check(q_tag.pop_front(), rd_data, q_exp.pop_front());
    end
  end

  task automatic rd(logic [2:0] a, logic [15:0] exp, string tag);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    q_exp.push_back(exp); q_tag.push_back(tag);
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_dma();
    @(negedge clk); dma_done = 1'b1;
    @(negedge clk); dma_done = 1'b0;
    mp[4] = 1'b1; sp[4] = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog R12 actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int c1, c2;
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // reset state
    rd(3'd0, 16'h0, "R1 reset main pend");
    rd(3'd4, 16'h0, "R11 reset sound pend");
    rd(3'd1, 16'h0, "R8 reset main en");
    check("R8 reset irq_main", 16'(irq_main), 16'h0);
    check("R8 reset irq_sound", 16'(irq_sound), 16'h0);

    // R1 R5: DMA with enables off
    pulse_dma(); idle(2);
    rd(3'd0, 16'(mp), "R1 dma main pend");
    rd(3'd4, 16'(sp), "R5 dma sound pend");
    check("R1 irq_main stays low while disabled", 16'(irq_main), 16'h0);

    // R5 timers A and C
    @(negedge clk); tmr_ovf = 3'b101;
    @(negedge clk); tmr_ovf = 3'b000;
    mp |= 11'h140; sp |= 11'h140;
    idle(2);
    rd(3'd0, 16'(mp), "R5 timer main pend");

    // R2 R11: clear main bit 4, sound untouched; zero write no effect
    wr(3'd2, 16'h0010); mp[4] = 1'b0;
    wr(3'd2, 16'h0000);
    rd(3'd0, 16'(mp), "R2 clear main bit4");
    rd(3'd4, 16'(sp), "R11 sound unaffected");

    // R3 software trigger
    wr(3'd0, 16'hFFDF);
    rd(3'd0, 16'(mp), "R3 writes other than bit5 ignored");
    wr(3'd0, 16'h0020); mp[5] = 1'b1;
    rd(3'd0, 16'(mp), "R3 bit5 sets");
    rd(3'd4, 16'(sp), "R3 sound no soft bit");

    // R9 R8 enable
    wr(3'd1, 16'hFFFF);
    rd(3'd1, 16'h07FF, "R9 upper enable bits read 0");
    rd(3'd2, 16'h0000, "R9 clear reg reads 0");
    idle(1);
    check("R8 irq_main high", 16'(irq_main), 16'h1);
    wr(3'd2, 16'h07FF); mp = '0;
    idle(2);
    check("R8 irq_main low after clear", 16'(irq_main), 16'h0);
    rd(3'd0, 16'h0, "R2 all cleared");

    // R4 external line 1
    @(negedge clk); ext_irq_n[1] = 1'b0;
    idle(6);
    mp[1] = 1'b1; sp[1] = 1'b1;
    rd(3'd0, 16'(mp), "R4 ext fall main");
    rd(3'd4, 16'(sp), "R4 ext fall sound");
    wr(3'd2, 16'h0002); mp[1] = 1'b0;
    idle(6);
    rd(3'd0, 16'(mp), "R4 held low no retrigger");
    @(negedge clk); ext_irq_n[1] = 1'b1;
    idle(6);
    rd(3'd0, 16'(mp), "R4 rising edge no set");

    // R6 level sources
    @(negedge clk); midi_out_empty = 1'b1; midi_in_avail = 1'b1;
    idle(1);
    rd(3'd4, 16'(sp | 11'h208), "R6 level bits follow");
    wr(3'd6, 16'h0208);
    rd(3'd4, 16'(sp | 11'h208), "R6 clear ignored while level high");
    @(negedge clk); midi_out_empty = 1'b0; midi_in_avail = 1'b0;
    idle(1);
    rd(3'd4, 16'(sp), "R6 level bits drop");

    // R7 same-cycle event and clear
    pulse_dma();
    @(negedge clk);
    dma_done = 1'b1; reg_wr = 1'b1; reg_addr = 3'd2; reg_wdata = 16'h0010;
    @(negedge clk);
    dma_done = 1'b0; reg_wr = 1'b0;
    idle(1);
    rd(3'd0, 16'(mp), "R7 set wins over clear");

    // R8 sound target
    wr(3'd5, 16'h0010);
    idle(1);
    check("R8 irq_sound high", 16'(irq_sound), 16'h1);
    wr(3'd5, 16'h0000);
    idle(1);
    check("R8 irq_sound low when disabled", 16'(irq_sound), 16'h0);

    // R10 tick interval via irq_main
    wr(3'd1, 16'h0400);
    wr(3'd2, 16'h07FF);
    idle(2);
    while (irq_main !== 1'b1) @(negedge clk);
    c1 = cyc;
    wr(3'd2, 16'h0400);
    while (irq_main !== 1'b0) @(negedge clk);
    while (irq_main !== 1'b1) @(negedge clk);
    c2 = cyc;
    check("R10 tick interval", 16'(c2 - c1), 16'(DIV));

    idle(4);
    check("R12 all reads returned", 16'(q_exp.size()), 16'h0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule